// File: doc/BRIEF.md
# ALU Condition-Code Flag Generator

This block is a width-parameterised integer ALU slice that produces a result word together with the four condition codes: negative, zero, overflow and carry. It covers addition, subtraction, compare, arithmetic shifts in both directions, and rotates in both directions through the carry flag. A small flag register holds the condition codes. It loads on a clock edge when the flag-write strobe is high, and a synchronous reset clears it.

The result word and its write enable are combinational from the operands, the operation code and the stored carry. The four flag outputs are the registered values. Overflow is worked out by a rule chosen per operation class. The arithmetic operations use a sign-agreement test on the operands and the result. The shift and rotate operations use the exclusive-OR of the new negative and carry flags.

Operation codes (3 bits): 0 add (dst + src), 1 subtract (dst − src), 2 compare (dst − src, no write), 3 shift left, 4 arithmetic shift right, 5 rotate left through carry, 6 rotate right through carry, 7 reserved. Shift and rotate operations act on `dst_i`.

Top module: `ccflag_alu`

## Requirements
- R1: Opcode 0 gives res_o = (dst_i + src_i) mod 2^W. Its carry is the unsigned carry-out, which is set exactly when the truncated sum is below either operand.
- R2: For opcode 0, V is set only when both operands share a sign and the sum's sign differs from that sign. Operands of opposite sign never set V. For example, all-ones plus all-ones gives all-ones minus one with V clear and C set.
- R3: For opcodes 0, 1 and 2, V equals the carry into the most significant bit XOR the carry out of it. For the subtract forms, the carry out is the inverse of the borrow.
- R4: N is bit W−1 of the result. Z is set exactly when every result bit is zero.
- R5: Opcode 1 gives res_o = (dst_i − src_i) mod 2^W. C is the borrow, which is set when unsigned src_i > dst_i. V is set when the operands differ in sign and the result's sign differs from dst_i's sign.
- R6: Opcode 2 produces the same four flags as opcode 1 and holds res_we_o low. Opcodes 0, 1 and 3 to 6 hold res_we_o high.
- R7: Opcode 3 shifts dst_i left by one and fills bit 0 with zero; C takes the old bit W−1. Opcode 4 shifts right by one and copies the old sign bit into bit W−1; C takes the old bit 0.
- R8: Opcode 5 rotates left, moving the stored C into bit 0 while the new C takes the old bit W−1. Opcode 6 rotates right, moving the stored C into bit W−1 while the new C takes the old bit 0.
- R9: For opcodes 3 to 6, V is set when exactly one of the new N and C is set.
- R10: The flags take the computed values on a rising edge with flag_we_i high and are unchanged on an edge with flag_we_i low.
- R11: A rising edge with rst_i high clears all four flags, whatever flag_we_i is.
- R12: Opcode 7 drives res_o = dst_i and res_we_o low, and writing flags under it leaves all four flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high, clears flags |
| op_i | input | 3 | Operation code |
| src_i | input | W | Source operand |
| dst_i | input | W | Destination operand (shifted/rotated operand) |
| flag_we_i | input | 1 | Flag register load strobe |
| res_o | output | W | Result word (combinational) |
| res_we_o | output | 1 | Result write enable (combinational) |
| flag_n_o | output | 1 | Stored negative flag |
| flag_z_o | output | 1 | Stored zero flag |
| flag_v_o | output | 1 | Stored overflow flag |
| flag_c_o | output | 1 | Stored carry/borrow flag |

## Verification
Sums of like-signed operands at the signed limits separate the sign-agreement overflow rule from the carry-out. Cases include the maximum positive value plus one, the most negative value plus itself, and all-ones plus all-ones. Opposite-sign sums and subtracts across zero separate borrow from overflow. Shifts chosen so that N and C are each set alone or together tell the exclusive-OR overflow rule apart from a plain copy of either flag. Rotates run with the stored carry both set and clear, long random sequences feed each carry back into the next rotate, and passes with the strobe low and with the reserved opcode show that the register holds.

// File: rtl/ccflag_pkg.sv
package ccflag_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_CMP = 3'd2,
      OP_ASL = 3'd3,
      OP_ASR = 3'd4,
      OP_ROL = 3'd5,
      OP_ROR = 3'd6,
      OP_NOP = 3'd7
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } ccflags_t;

   function automatic logic is_arith(input alu_op_e op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
   endfunction

   function automatic logic is_shift(input alu_op_e op);
      return (op == OP_ASL) || (op == OP_ASR) || (op == OP_ROL) || (op == OP_ROR);
   endfunction

endpackage

// File: rtl/ccflag_adder.sv
// Adder exposing the carry into and out of the sign bit.
// STYLE 0: behavioural split add, STYLE 1: explicit ripple chain.
module ccflag_adder #(
   parameter int W     = 16,
   parameter int STYLE = 0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         c_msb_o,
   output logic         cout_o
);
   localparam int LOW = W - 1;

   if (W < 2) begin : g_bad_width
      $error("ccflag_adder: W must be at least 2");
   end
   if (STYLE != 0 && STYLE != 1) begin : g_bad_style
      $error("ccflag_adder: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_behav
      logic [LOW:0] low_sum;
      always_comb begin
         low_sum  = {1'b0, a_i[LOW-1:0]} + {1'b0, b_i[LOW-1:0]} + {{LOW{1'b0}}, cin_i};
         c_msb_o  = low_sum[LOW];
         sum_o    = {a_i[W-1] ^ b_i[W-1] ^ low_sum[LOW], low_sum[LOW-1:0]};
         cout_o   = (a_i[W-1] & b_i[W-1]) | (low_sum[LOW] & (a_i[W-1] ^ b_i[W-1]));
      end
   end else begin : g_ripple
      logic [W:0] cy;
      assign cy[0] = cin_i;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign sum_o[i]  = a_i[i] ^ b_i[i] ^ cy[i];
         assign cy[i+1]   = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
      end
      assign c_msb_o = cy[W-1];
      assign cout_o  = cy[W];
   end

endmodule

// File: rtl/ccflag_shifter.sv
// Single-bit shift / rotate unit operating on the destination operand.
module ccflag_shifter
   import ccflag_pkg::*;
#(
   parameter int W = 16
) (
   input  alu_op_e      op_i,
   input  logic [W-1:0] d_i,
   input  logic         cin_i,
   output logic [W-1:0] res_o,
   output logic         cout_o
);
   if (W < 2) begin : g_bad_width
      $error("ccflag_shifter: W must be at least 2");
   end

   always_comb begin
      res_o  = d_i;
      cout_o = 1'b0;
      unique case (op_i)
         OP_ASL: begin res_o = {d_i[W-2:0], 1'b0};     cout_o = d_i[W-1]; end
         OP_ASR: begin res_o = {d_i[W-1], d_i[W-1:1]}; cout_o = d_i[0];   end
         OP_ROL: begin res_o = {d_i[W-2:0], cin_i};    cout_o = d_i[W-1]; end
         OP_ROR: begin res_o = {cin_i, d_i[W-1:1]};    cout_o = d_i[0];   end
         default: begin res_o = d_i; cout_o = 1'b0; end
      endcase
   end

endmodule

// File: rtl/ccflag_reg.sv
// Condition-code register: synchronous clear, strobed load.
module ccflag_reg
   import ccflag_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_i,
   input  logic     we_i,
   input  ccflags_t d_i,
   output ccflags_t q_o
);
   always_ff @(posedge clk_i) begin
      if (rst_i)     q_o <= '0;
      else if (we_i) q_o <= d_i;
   end

   assert_clear_R11: assert property (@(posedge clk_i)
      $past(rst_i) |-> (q_o == '0));

   assert_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      !we_i |=> $stable(q_o));

endmodule

// File: rtl/ccflag_alu.sv
module ccflag_alu
   import ccflag_pkg::*;
#(
   parameter int W           = 16,
   parameter int ADDER_STYLE = 0
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [2:0]   op_i,
   input  logic [W-1:0] src_i,
   input  logic [W-1:0] dst_i,
   input  logic         flag_we_i,
   output logic [W-1:0] res_o,
   output logic         res_we_o,
   output logic         flag_n_o,
   output logic         flag_z_o,
   output logic         flag_v_o,
   output logic         flag_c_o
);
   localparam int MSB = W - 1;

   if (W < 2) begin : g_bad_width
      $error("ccflag_alu: W must be at least 2");
   end

   alu_op_e     op;
   ccflags_t    cur, nxt;
   logic [W-1:0] add_b, add_sum, sh_res;
   logic        add_cin, c_msb, c_out, sh_cout;
   logic        is_sub, v_sign;

   assign op     = alu_op_e'(op_i);
   assign is_sub = (op == OP_SUB) || (op == OP_CMP);

   always_comb begin
      add_b   = is_sub ? ~src_i : src_i;
      add_cin = is_sub;
   end

   ccflag_adder #(.W(W), .STYLE(ADDER_STYLE)) u_adder (
      .a_i    (dst_i),
      .b_i    (add_b),
      .cin_i  (add_cin),
      .sum_o  (add_sum),
      .c_msb_o(c_msb),
      .cout_o (c_out)
   );

   ccflag_shifter #(.W(W)) u_shift (
      .op_i  (op),
      .d_i   (dst_i),
      .cin_i (cur.c),
      .res_o (sh_res),
      .cout_o(sh_cout)
   );

   // Sign-agreement overflow rule, from operand and result signs only.
   always_comb begin
      if (is_sub)
         v_sign = (dst_i[MSB] != src_i[MSB]) && (add_sum[MSB] != dst_i[MSB]);
      else
         v_sign = (dst_i[MSB] == src_i[MSB]) && (add_sum[MSB] != dst_i[MSB]);
   end

   always_comb begin
      res_o    = dst_i;
      res_we_o = 1'b0;
      nxt      = cur;
      if (is_arith(op)) begin
         res_o    = add_sum;
         res_we_o = (op != OP_CMP);
         nxt.n    = add_sum[MSB];
         nxt.z    = (add_sum == '0);
         nxt.v    = v_sign;
         nxt.c    = is_sub ? ~c_out : c_out;
      end else if (is_shift(op)) begin
         res_o    = sh_res;
         res_we_o = 1'b1;
         nxt.n    = sh_res[MSB];
         nxt.z    = (sh_res == '0);
         nxt.c    = sh_cout;
         nxt.v    = sh_res[MSB] ^ sh_cout;
      end
   end

   ccflag_reg u_flags (
      .clk_i(clk_i),
      .rst_i(rst_i),
      .we_i (flag_we_i),
      .d_i  (nxt),
      .q_o  (cur)
   );

   assign flag_n_o = cur.n;
   assign flag_z_o = cur.z;
   assign flag_v_o = cur.v;
   assign flag_c_o = cur.c;

   assert_v_carry_form_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      is_arith(op) |-> (v_sign == (c_msb ^ c_out)));

   assert_n_follows_msb_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (flag_we_i && op != OP_NOP) |=> (flag_n_o == $past(res_o[MSB])));

   assert_shift_v_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      (flag_we_i && is_shift(op)) |=> (flag_v_o == (flag_n_o ^ flag_c_o)));

   assert_cmp_no_write_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (op == OP_CMP || op == OP_NOP) |-> !res_we_o);

   assert_nop_keeps_R12: assert property (@(posedge clk_i) disable iff (rst_i)
      (op == OP_NOP) |=> $stable({flag_n_o, flag_z_o, flag_v_o, flag_c_o}));

endmodule

// File: tb/ccflag_alu_bench.sv
module ccflag_alu_bench;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [2:0]   op = 3'd7;
   logic [W-1:0] src = '0, dst = '0;
   logic         fwe = 1'b0;
   logic [W-1:0] res;
   logic         res_we, fn, fz, fv, fc;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // model state
   logic m_n = 0, m_z = 0, m_v = 0, m_c = 0;

   always #4 clk = ~clk;   // 125 MHz

   ccflag_alu #(.W(W)) u_ccflag_alu (
      .clk_i(clk), .rst_i(rst), .op_i(op), .src_i(src), .dst_i(dst),
      .flag_we_i(fwe), .res_o(res), .res_we_o(res_we),
      .flag_n_o(fn), .flag_z_o(fz), .flag_v_o(fv), .flag_c_o(fc)
   );

   task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic string op_req(input logic [2:0] o);
      case (o)
         3'd0: return "R1";
         3'd1: return "R5";
         3'd2: return "R6";
         3'd3, 3'd4: return "R7";
         3'd5, 3'd6: return "R8";
         default: return "R12";
      endcase
   endfunction

   task automatic step(input logic [2:0] o, input logic [W-1:0] d, input logic [W-1:0] s, input logic we);
      logic [W-1:0] r;
      logic [W:0]   wide;
      logic [W-1:0] low;
      logic         en, n, z, v, c, vform, cout;
      @(negedge clk);
      op = o; dst = d; src = s; fwe = we;
      r = d; en = 1'b0; n = m_n; z = m_z; v = m_v; c = m_c; vform = 1'b0;
      case (o)
         3'd0: begin
            wide = {1'b0, d} + {1'b0, s};
            r = wide[W-1:0]; c = wide[W]; en = 1'b1;
            v = (d[W-1] == s[W-1]) && (r[W-1] != d[W-1]);
            low = {1'b0, d[W-2:0]} + {1'b0, s[W-2:0]};
            vform = low[W-1] ^ c;
         end
         3'd1, 3'd2: begin
            r = d - s; c = (s > d); en = (o == 3'd1);
            v = (d[W-1] != s[W-1]) && (r[W-1] != d[W-1]);
            low = {1'b0, d[W-2:0]} + {1'b0, ~s[W-2:0]} + 1;
            cout = ~c;
            vform = low[W-1] ^ cout;
         end
         3'd3: begin r = d << 1; c = d[W-1]; en = 1'b1; end
         3'd4: begin r = {d[W-1], d[W-1:1]}; c = d[0]; en = 1'b1; end
         3'd5: begin r = {d[W-2:0], m_c}; c = d[W-1]; en = 1'b1; end
         3'd6: begin r = {m_c, d[W-1:1]}; c = d[0]; en = 1'b1; end
         default: ;
      endcase
      if (o != 3'd7) begin
         n = r[W-1];
         z = (r == '0);
         if (o >= 3'd3) v = n ^ c;
      end
      #1;
      chk(op_req(o), "res", res, r);
      chk("R6", "res_we", W'(res_we), W'(en));
      @(posedge clk);
      if (we) begin m_n = n; m_z = z; m_v = v; m_c = c; end
      #2;
      chk("R4", "N", W'(fn), W'(m_n));
      chk("R4", "Z", W'(fz), W'(m_z));
      chk(op_req(o), "C", W'(fc), W'(m_c));
      if (o <= 3'd2 && we) begin
         chk("R3", "V carry form", W'(fv), W'(vform));
         if (o == 3'd0) begin
            chk("R2", "V sign rule", W'(fv), W'(v));
            chk("R1", "C vs truncation", W'(fc), W'((r < d) || (r < s)));
         end
      end else if (o != 3'd7 && we) chk("R9", "V", W'(fv), W'(m_v));
      else chk(we ? "R12" : "R10", "V", W'(fv), W'(m_v));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("R11", "reset flags", W'({fn, fz, fv, fc}), '0);
      @(negedge clk); rst = 1'b0;

      step(3'd0, 16'h0001, 16'h0001, 1);          // R1 plain add
      step(3'd0, 16'h7FFF, 16'h0001, 1);          // R2 positive overflow
      step(3'd0, 16'hFFFF, 16'hFFFF, 1);          // R2 -1 + -1 : V0 C1
      step(3'd0, 16'h8000, 16'h8000, 1);          // R2 negative overflow, Z, C
      step(3'd0, 16'h7FFF, 16'h8000, 1);          // R2 opposite signs
      step(3'd1, 16'h0005, 16'h0003, 1);          // R5
      step(3'd1, 16'h0003, 16'h0005, 1);          // R5 borrow
      step(3'd1, 16'h8000, 16'h0001, 1);          // R5 overflow
      step(3'd2, 16'h1234, 16'h1234, 1);          // R6 compare equal
      step(3'd2, 16'h7FFF, 16'hFFFF, 1);          // R6 compare overflow
      step(3'd3, 16'h4000, 16'h0000, 1);          // R7/R9 N only
      step(3'd3, 16'hC000, 16'h0000, 1);          // R9 N and C
      step(3'd3, 16'h8000, 16'h0000, 1);          // R9 C only, Z
      step(3'd4, 16'h8001, 16'h0000, 1);          // R7 sign copy
      step(3'd5, 16'h0001, 16'h0000, 1);          // R8 rotate with C=1 from before
      step(3'd6, 16'h0001, 16'h0000, 1);          // R8
      step(3'd6, 16'h0000, 16'h0000, 1);          // R8 C=1 into msb
      step(3'd0, 16'h7FFF, 16'h7FFF, 0);          // R10 hold
      step(3'd7, 16'hABCD, 16'h0000, 1);          // R12 reserved
      for (int i = 0; i < 400; i++)
         step(3'($urandom_range(0, 7)), W'($urandom), W'($urandom), 1'($urandom_range(0, 3) != 0));
      @(negedge clk); rst = 1'b1; fwe = 1'b1; op = 3'd0; dst = 16'h8000; src = 16'h8000;
      @(posedge clk); #2;
      m_n = 0; m_z = 0; m_v = 0; m_c = 0;
      chk("R11", "mid-run reset", W'({fn, fz, fv, fc}), '0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule